// File: doc/BRIEF.md
# Flash Program/Erase Job Sequencer

This block sits on the host side of a byte-wide parallel flash command interface. A client hands it one job at a time: either a byte program (target address plus data byte) or a block erase (any address inside the block). The sequencer issues the command writes on a simple strobe bus. It then keeps reading the device status until the ready flag comes up and examines the error flags in a fixed order. If anything went wrong it sends the clear-status command, and it always finishes by putting the device back into array read mode.

Each bus access is a single-cycle strobe, and address and data are valid in that cycle. The device answers a read strobe with its status byte on the following cycle. A poll limit input bounds how long the sequencer keeps polling a busy device. When the job is over, a one-cycle completion pulse carries a 3-bit result code.

Top module: `nvm_job_seq`

## Requirements
- R1: After reset, and whenever no job is running, `reqReady` is 1 and `busWe`, `busRe` and `done` are 0.
- R2: A program job writes 8'h40 and then the job data byte, both at the job address, on two consecutive cycles.
- R3: An erase job writes 8'h20 and then 8'hD0, both at the job address, on two consecutive cycles.
- R4: After the command writes, the sequencer issues one read strobe at the job address every second cycle. It stops only when a returned status has bit 7 set or the poll limit is reached, and it ignores every other status bit on a busy read.
- R5: On a ready status, bit 3 is checked first. If it is set, the result is code 1 (voltage range error), whatever the other bits hold.
- R6: On an erase with bit 3 clear, bits 5 and 4 both set give code 4 (command sequence error). Otherwise bit 5 set gives code 3 (erase error), and anything else gives code 0 (success).
- R7: On a program with bit 3 clear, bit 4 set gives code 2 (program error), and anything else gives code 0.
- R8: Status bits 2..0 and bit 6 never change the result. Bit 5 does not affect a program job, and bit 4 alone does not affect an erase job.
- R9: A job with a nonzero result writes 8'h50 (clear status) and then 8'hFF. A successful job writes only 8'hFF. Both writes go to the job address.
- R10: If `pollLimit` consecutive reads (at least one) all return bit 7 clear, the job ends with code 5 (timeout).
- R11: A request is taken only while `reqReady` is 1. `reqValid` and the request fields have no effect while a job runs.
- R12: `done` is a one-cycle pulse that comes one cycle after the 8'hFF write, with `result` valid in the same cycle. `reqReady` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Job request strobe |
| reqErase | input | 1 | 1 = block erase, 0 = byte program |
| reqAddr | input | ADDR_W | Byte address or address inside the block |
| reqData | input | 8 | Byte to program |
| pollLimit | input | LIMIT_W | Number of busy reads that ends the job with a timeout |
| reqReady | output | 1 | Sequencer idle and able to take a job |
| busWe | output | 1 | Single-cycle write strobe |
| busRe | output | 1 | Single-cycle status read strobe |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | 8 | Bus write data |
| busRdata | input | 8 | Status byte, valid the cycle after `busRe` |
| done | output | 1 | Job-complete pulse |
| result | output | 3 | Result code (0 ok, 1 voltage, 2 program, 3 erase, 4 sequence, 5 timeout) |

## Verification
The bench builds the sequencer with an 8-bit address and a 4-bit poll limit. This keeps every poll limit from 0 to 15 within a few dozen cycles, so both timeout boundaries can be reached. For each job type, the bench sweeps all sixteen combinations of status bits 6..3 behind a ready flag. It varies the reserved bits and the number of busy reads along with them, so that every branch of the fixed check order and the masking of unused bits are covered. A model of the device logs every bus write and poll. The bench compares that log, the latency and the result code against values it derives from the job and the injected status.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_VPP     = 3'd1,
    RES_PROG    = 3'd2,
    RES_ERASE   = 3'd3,
    RES_SEQ     = 3'd4,
    RES_TIMEOUT = 3'd5
  } resCode_t;

  typedef struct packed {
    logic loadJob;
    logic cmdSetup;
    logic cmdConfirm;
    logic pollRead;
    logic cmdClear;
    logic cmdArray;
    logic bumpCount;
    logic takeResult;
    logic takeTimeout;
    logic finish;
  } seqStrobe_t;

  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] STAT_MASK      = 8'hF8;

endpackage

// File: rtl/nvm_seq_dp.sv
module nvm_seq_dp
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         st,
  input  logic               reqErase,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqData,
  input  logic [LIMIT_W-1:0] pollLimit,
  input  logic [7:0]         busRdata,
  output logic               busWe,
  output logic               busRe,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [7:0]         busWdata,
  output logic               statReady,
  output resCode_t           statCode,
  output logic               limitHit,
  output logic [2:0]         result
);

  localparam int CNT_W = LIMIT_W + 1;

  logic [ADDR_W-1:0] jobAddr;
  logic [7:0]        jobData;
  logic              jobErase;
  logic [CNT_W-1:0]  busyCnt;
  resCode_t          resultReg;
  logic [7:0]        statNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jobAddr  <= '0;
      jobData  <= '0;
      jobErase <= 1'b0;
    end else if (st.loadJob) begin
      jobAddr  <= reqAddr;
      jobData  <= reqData;
      jobErase <= reqErase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.loadJob) busyCnt <= '0;
    else if (st.bumpCount)   busyCnt <= busyCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.loadJob) resultReg <= RES_OK;
    else if (st.takeTimeout) resultReg <= RES_TIMEOUT;
    else if (st.takeResult)  resultReg <= statCode;
  end

  // Reserved bits are dropped before any decision is made.
  assign statNow   = busRdata & STAT_MASK;
  assign statReady = statNow[7];
  assign limitHit  = (busyCnt + 1'b1) >= {1'b0, pollLimit};

  // Fixed check order: supply range, then the operation's own flags.
  always_comb begin
    statCode = RES_OK;
    if (statNow[3])                              statCode = RES_VPP;
    else if (jobErase && statNow[5] && statNow[4]) statCode = RES_SEQ;
    else if (jobErase && statNow[5])             statCode = RES_ERASE;
    else if (!jobErase && statNow[4])            statCode = RES_PROG;
  end

  assign busWe   = st.cmdSetup | st.cmdConfirm | st.cmdClear | st.cmdArray;
  assign busRe   = st.pollRead;
  assign busAddr = jobAddr;
  assign result  = resultReg;

  always_comb begin
    busWdata = 8'h00;
    if (st.cmdSetup)        busWdata = jobErase ? OP_ERASE_SETUP : OP_PROG_SETUP;
    else if (st.cmdConfirm) busWdata = jobErase ? OP_ERASE_GO : jobData;
    else if (st.cmdClear)   busWdata = OP_CLEAR_STAT;
    else if (st.cmdArray)   busWdata = OP_READ_ARRAY;
  end

endmodule

// File: rtl/nvm_seq_ctl.sv
module nvm_seq_ctl
  import nvm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       statReady,
  input  resCode_t   statCode,
  input  logic       limitHit,
  output seqStrobe_t st,
  output logic       reqReady
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_POLL, S_WAIT, S_CLEAR, S_ARRAY, S_FIN
  } seqState_t;

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    st        = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          st.loadJob = 1'b1;
          nextState  = S_SETUP;
        end
      end
      S_SETUP: begin
        st.cmdSetup = 1'b1;
        nextState   = S_CONFIRM;
      end
      S_CONFIRM: begin
        st.cmdConfirm = 1'b1;
        nextState     = S_POLL;
      end
      S_POLL: begin
        st.pollRead = 1'b1;
        nextState   = S_WAIT;
      end
      S_WAIT: begin
        if (statReady) begin
          st.takeResult = 1'b1;
          nextState     = (statCode != RES_OK) ? S_CLEAR : S_ARRAY;
        end else if (limitHit) begin
          st.takeTimeout = 1'b1;
          nextState      = S_CLEAR;
        end else begin
          st.bumpCount = 1'b1;
          nextState    = S_POLL;
        end
      end
      S_CLEAR: begin
        st.cmdClear = 1'b1;
        nextState   = S_ARRAY;
      end
      S_ARRAY: begin
        st.cmdArray = 1'b1;
        nextState   = S_FIN;
      end
      S_FIN: begin
        st.finish = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);

endmodule

// File: rtl/nvm_job_seq.sv
module nvm_job_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqErase,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [7:0]         reqData,
  input  logic [LIMIT_W-1:0] pollLimit,
  output logic               reqReady,
  output logic               busWe,
  output logic               busRe,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [7:0]         busWdata,
  input  logic [7:0]         busRdata,
  output logic               done,
  output logic [2:0]         result
);

  seqStrobe_t st;
  logic       statReady;
  resCode_t   statCode;
  logic       limitHit;

  nvm_seq_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .statReady(statReady),
    .statCode (statCode),
    .limitHit (limitHit),
    .st       (st),
    .reqReady (reqReady)
  );

  nvm_seq_dp #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .reqErase (reqErase),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .pollLimit(pollLimit),
    .busRdata (busRdata),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .statReady(statReady),
    .statCode (statCode),
    .limitHit (limitHit),
    .result   (result)
  );

  assign done = st.finish;

endmodule

// File: rtl/nvm_job_seq_chk.sv
module nvm_job_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       busWe,
  input logic       busRe,
  input logic [7:0] busWdata,
  input logic       done,
  input logic [2:0] result
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busWe && !busRe && !done)); // R1

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe)); // R4

  AST_POLL_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> !busRe); // R4

  AST_ARRAY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busWe) && $past(busWdata) == 8'hFF)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady)); // R12

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result <= 3'd5)); // R12

endmodule

bind nvm_job_seq nvm_job_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .busWe   (busWe),
  .busRe   (busRe),
  .busWdata(busWdata),
  .done    (done),
  .result  (result)
);

// File: tb/sim_nvm_job_seq.sv
`timescale 1ns/1ps
module sim_nvm_job_seq;

  localparam int AW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqErase = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic [LW-1:0] pollLimit = 4'd8;
  logic          reqReady, busWe, busRe, done;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWdata;
  logic [7:0]    busRdata = 8'h00;
  logic [2:0]    result;

  always #2 clk = ~clk;

  nvm_job_seq #(.ADDR_W(AW), .LIMIT_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqData(reqData), .pollLimit(pollLimit),
    .reqReady(reqReady), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .done(done), .result(result)
  );

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  // Device model: logs writes and polls, answers polls on the next cycle.
  logic [AW-1:0] logA [0:511];
  logic [7:0]    logD [0:511];
  int            wrN = 0;
  int            rdN = 0;
  int            rdBase = 0;
  int            busyPolls = 0;
  logic [7:0]    devStat = 8'h80;
  logic [AW-1:0] pollAddr = '0;

  always @(negedge clk) begin
    cycle <= cycle + 1;
    if (busWe) begin
      logA[wrN] <= busAddr;
      logD[wrN] <= busWdata;
      wrN <= wrN + 1;
    end
    if (busRe) begin
      pollAddr <= busAddr;
      busRdata <= ((rdN - rdBase) < busyPolls) ? (devStat & 8'h7F) : devStat;
      rdN <= rdN + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int classify(input logic [7:0] s, input bit er);
    if (s[3]) return 1;
    if (er && s[5] && s[4]) return 4;
    if (er && s[5]) return 3;
    if (!er && s[4]) return 2;
    return 0;
  endfunction

  task automatic runJob(input bit er, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [7:0] s, input int busy, input int lim, input bit holdReq);
    int lim1, polls, expRes, e, cyc, w0, r0, expW;
    logic [7:0] expD [0:3];
    lim1 = (lim == 0) ? 1 : lim;
    if (busy >= lim1) begin expRes = 5; polls = lim1; end
    else begin expRes = classify(s, er); polls = busy + 1; end
    e = (expRes != 0) ? 1 : 0;
    expD[0] = er ? 8'h20 : 8'h40;
    expD[1] = er ? 8'hD0 : d;
    expD[2] = e ? 8'h50 : 8'hFF;
    expD[3] = 8'hFF;
    expW = 3 + e;
    @(negedge clk);
    w0 = wrN; r0 = rdN; rdBase = rdN;
    devStat = s; busyPolls = busy; pollLimit = lim[LW-1:0];
    reqValid = 1'b1; reqErase = er; reqAddr = a; reqData = d;
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    if (holdReq) begin reqErase = ~er; reqAddr = ~a; reqData = ~d; end
    else reqValid = 1'b0;
    while (!done) begin @(negedge clk); cyc++; end
    reqValid = 1'b0;
    chk(result == expRes[2:0], $sformatf("R5/R6/R7/R8/R10 result er=%0d st=%0h busy=%0d lim=%0d",
        er, s, busy, lim), result, expRes);
    chk(cyc == 4 + 2*polls + e, "R12 done latency", cyc, 4 + 2*polls + e);
    chk(rdN - r0 == polls, "R4 poll count", rdN - r0, polls);
    chk(pollAddr == a, "R4 poll address", pollAddr, a);
    chk(wrN - w0 == expW, "R9 write count", wrN - w0, expW);
    if (wrN - w0 == expW) begin
      for (int i = 0; i < expW; i++) begin
        chk(logD[w0+i] == expD[i], er ? "R3/R9 write data" : "R2/R9 write data", logD[w0+i], expD[i]);
        chk(logA[w0+i] == a, "R2/R3 write address", logA[w0+i], a);
      end
    end
    @(negedge clk);
    chk(!done && reqReady, "R12 done one cycle then ready", {done, reqReady}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && !busWe && !busRe && !done, "R1 in reset", {reqReady, busWe, busRe, done}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady && !busWe && !busRe && !done, "R1 after reset", {reqReady, busWe, busRe, done}, 4'b1000);

    // Sweep status bits 6..3 for both job types; vary reserved bits and busy reads.
    for (int er = 0; er < 2; er++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] s;
        s = {1'b1, k[3:0], 3'(k * 3 + er)};
        runJob(er[0], 8'(k * 17 + er * 5), 8'(k * 29 + 3), s, k % 3, 8, 1'b0);
      end
    end

    // Poll limit boundaries (R10): just under, at, and zero limit.
    runJob(1'b0, 8'h3C, 8'h5A, 8'h80, 2, 3, 1'b0);
    runJob(1'b0, 8'h3D, 8'h5B, 8'h80, 3, 3, 1'b0);
    runJob(1'b1, 8'h77, 8'h00, 8'h80, 9, 15, 1'b0);
    runJob(1'b1, 8'h78, 8'h00, 8'h88, 15, 15, 1'b0);
    runJob(1'b0, 8'h10, 8'hAA, 8'h80, 1, 0, 1'b0);
    runJob(1'b0, 8'h11, 8'hAB, 8'h80, 0, 0, 1'b0);

    // R11: request held and fields changed while busy.
    runJob(1'b0, 8'hC3, 8'h96, 8'h90, 1, 8, 1'b1);
    begin
      int w1;
      w1 = wrN;
      repeat (4) @(negedge clk);
      chk(wrN == w1 && reqReady, "R11 no job started by stale request", wrN - w1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cycle == 20000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule